// File: doc/BRIEF.md
# Configurable Port Pin Controller

This block drives and senses a small group of bidirectional port pins in a device that pairs a microcontroller with programmable logic. The CPU reaches five control registers over a simple register bus. For each pin, the block picks the output value from one of two sources: the CPU's data-out bit or a chip-select line from the address decoder. It picks the output enable from one of two sources as well: a product-term enable from the logic array or the CPU's direction bit. It also presents a drive-type bit for each pin.

Every pin input goes straight to the programmable-logic input bus with no register in the path. Pins 1 and 2 are also sent to the power-management logic. A two-flop synchronized copy of the pins is what the CPU reads back.

Two pins can be given dedicated roles. Pin 1 can act as the common clock for the output macrocells. Pin 2 can act as an active-high chip-select input that forces every memory select into standby. A pin given a dedicated role is always an input.

Top module: `port_pin_ctrl`

## Requirements
- R1: After reset, the data-out, direction and drive registers (addresses 1, 2 and 3) all read back as 0.
- R2: A bus cycle with `bus_sel`=1 and `bus_wr`=1 at address 1, 2 or 3 stores `bus_wdata` at the clock edge. Reads of those addresses return the stored value. A write cycle at any other address changes none of them.
- R3: When `cfg_out_cs[i]`=1, `pin_out[i]` equals `ext_cs[i]`. Otherwise it equals data-out register bit i.
- R4: When `cfg_oe_pt[i]`=1, the pin's enable follows `pt_oe[i]`. Otherwise it follows direction register bit i, where 1 means output and 0 means input (tri-stated). `pin_oe[i]` is this value unless R5 applies.
- R5: `pin_oe[1]` is 0 whenever `cfg_clk_pin`=1, and `pin_oe[2]` is 0 whenever `cfg_csi_pin`=1.
- R6: `pin_fast[i]` equals drive register bit i. A value of 1 requests fast slew-rate drive.
- R7: `pld_in` equals `pin_in` in the same cycle. `pm_in` equals `pin_in[2:1]`.
- R8: A read at address 0 returns `pin_in` as it was two clock edges earlier. Writes to address 0 are ignored.
- R9: A read at address 4 returns the effective `pin_oe` after source selection and the R5 forcing. Writes to address 4 are ignored. Reads at addresses 5 to 7 return 0.
- R10: `mc_clk` equals `pin_in[1]` when `cfg_clk_pin`=1, and is 0 otherwise.
- R11: When `cfg_csi_pin`=1 and `pin_in[2]`=1, `mem_sel_out` is all zeros (standby). Otherwise it equals `mem_sel_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select: 0 data-in, 1 data-out, 2 direction, 3 drive, 4 enable-out |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| cfg_out_cs | input | NPINS | Per-pin output source: 1 = decoder chip-select |
| cfg_oe_pt | input | NPINS | Per-pin enable source: 1 = product-term enable |
| cfg_clk_pin | input | 1 | Pin 1 is the macrocell clock input |
| cfg_csi_pin | input | 1 | Pin 2 is the memory chip-select input |
| ext_cs | input | NPINS | Chip-selects from the address decoder |
| pt_oe | input | NPINS | Product-term output enables |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| pin_fast | output | NPINS | Fast slew-rate request |
| pld_in | output | NPINS | Pin values to the logic input bus |
| pm_in | output | 2 | Pins 2 and 1 to power management |
| mc_clk | output | 1 | Common macrocell clock |
| mem_sel_in | input | NMEM | Internal memory selects |
| mem_sel_out | output | NMEM | Memory selects after standby forcing |

## Verification
A corrupted data-out, direction or drive bit shows up in the same cycle it goes wrong. It appears on `pin_out`, `pin_oe` or `pin_fast` for any pin that uses the CPU source, and on the next read of that register. A synchronizer that is a stage short or a stage long returns a data-in read one edge early or late. Random pin values expose that after the first few cycles. A missed standby force or a missed dedicated-pin tri-state is visible at once on `mem_sel_out` or `pin_oe`, with no clock edge needed.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIN  = 3'd0,
    A_DOUT = 3'd1,
    A_DIR  = 3'd2,
    A_DRV  = 3'd3,
    A_OEN  = 3'd4
  } reg_addr_e;

  // Two-way source pick used for both the value and the enable paths.
  function automatic logic pick_src(input logic use_alt, input logic alt, input logic cpu);
    return use_alt ? alt : cpu;
  endfunction
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
  import pinctl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      dout_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      drv_q
);
  logic wr_any, wr_dout, wr_dir, wr_drv;

  assign wr_any  = sel && wr;
  assign wr_dout = wr_any && (addr == A_DOUT);
  assign wr_dir  = wr_any && (addr == A_DIR);
  assign wr_drv  = wr_any && (addr == A_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_drv)  drv_q  <= wdata;
    end
  end

  // R2
  dout_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> dout_q == $past(wdata));

  // R8
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && (addr == A_DIN || addr == A_OEN)) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(drv_q)));
endmodule

// File: rtl/pinctl_pin_mux.sv
module pinctl_pin_mux
  import pinctl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cfg_out_cs,
  input  logic [N-1:0] cfg_oe_pt,
  input  logic         cfg_clk_pin,
  input  logic         cfg_csi_pin,
  input  logic [N-1:0] ext_cs,
  input  logic [N-1:0] pt_oe,
  input  logic [N-1:0] dout_q,
  input  logic [N-1:0] dir_q,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  logic [N-1:0] oe_sel;
  logic [N-1:0] dedicated;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin_out[i] = pick_src(cfg_out_cs[i], ext_cs[i], dout_q[i]);
    assign oe_sel[i]  = pick_src(cfg_oe_pt[i], pt_oe[i], dir_q[i]);
    if (i == 1) begin : g_clk
      assign dedicated[i] = cfg_clk_pin;
    end else if (i == 2) begin : g_csi
      assign dedicated[i] = cfg_csi_pin;
    end else begin : g_plain
      assign dedicated[i] = 1'b0;
    end
    assign pin_oe[i] = oe_sel[i] && !dedicated[i];
  end

  // R5
  clk_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_pin |-> !pin_oe[1]);

  // R5
  csi_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_csi_pin |-> !pin_oe[2]);
endmodule

// File: rtl/port_pin_ctrl.sv
module port_pin_ctrl
  import pinctl_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NMEM  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  cfg_out_cs,
  input  logic [NPINS-1:0]  cfg_oe_pt,
  input  logic              cfg_clk_pin,
  input  logic              cfg_csi_pin,
  input  logic [NPINS-1:0]  ext_cs,
  input  logic [NPINS-1:0]  pt_oe,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_fast,
  output logic [NPINS-1:0]  pld_in,
  output logic [1:0]        pm_in,
  output logic              mc_clk,
  input  logic [NMEM-1:0]   mem_sel_in,
  output logic [NMEM-1:0]   mem_sel_out
);
  logic [NPINS-1:0] dout_q, dir_q, drv_q, din_sync;
  logic             csi_force;

  pinctl_regs #(.N(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dout_q(dout_q), .dir_q(dir_q), .drv_q(drv_q)
  );

  pinctl_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_sync)
  );

  pinctl_pin_mux #(.N(NPINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .cfg_out_cs(cfg_out_cs), .cfg_oe_pt(cfg_oe_pt),
    .cfg_clk_pin(cfg_clk_pin), .cfg_csi_pin(cfg_csi_pin), .ext_cs(ext_cs),
    .pt_oe(pt_oe), .dout_q(dout_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign pin_fast  = drv_q;
  assign pld_in    = pin_in;
  assign pm_in     = pin_in[2:1];
  assign mc_clk    = cfg_clk_pin && pin_in[1];
  assign csi_force = cfg_csi_pin && pin_in[2];
  assign mem_sel_out = csi_force ? '0 : mem_sel_in;

  always_comb begin
    case (bus_addr)
      A_DIN:   bus_rdata = din_sync;
      A_DOUT:  bus_rdata = dout_q;
      A_DIR:   bus_rdata = dir_q;
      A_DRV:   bus_rdata = drv_q;
      A_OEN:   bus_rdata = pin_oe;
      default: bus_rdata = '0;
    endcase
  end

  // R11
  standby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csi_force |-> (mem_sel_out == '0));
endmodule

// File: tb/port_pin_ctrl_test.sv
module port_pin_ctrl_test;
  localparam int N = 8;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] cfg_out_cs = '0, cfg_oe_pt = '0;
  logic cfg_clk_pin = 1'b0, cfg_csi_pin = 1'b0;
  logic [N-1:0] ext_cs = '0, pt_oe = '0, pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pin_fast, pld_in;
  logic [1:0] pm_in;
  logic mc_clk;
  logic [M-1:0] mem_sel_in = '0, mem_sel_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_dout = '0, m_dir = '0, m_drv = '0, m_p1 = '0, m_p2 = '0;

  always #4 clk = ~clk;

  port_pin_ctrl #(.NPINS(N), .NMEM(M)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_out_cs(cfg_out_cs),
    .cfg_oe_pt(cfg_oe_pt), .cfg_clk_pin(cfg_clk_pin), .cfg_csi_pin(cfg_csi_pin),
    .ext_cs(ext_cs), .pt_oe(pt_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_fast(pin_fast), .pld_in(pld_in), .pm_in(pm_in), .mc_clk(mc_clk),
    .mem_sel_in(mem_sel_in), .mem_sel_out(mem_sel_out)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = cfg_out_cs[i] ? ext_cs[i] : m_dout[i];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = cfg_oe_pt[i] ? pt_oe[i] : m_dir[i];
    if (cfg_clk_pin) r[1] = 1'b0;
    if (cfg_csi_pin) r[2] = 1'b0;
    return r;
  endfunction

  function automatic logic [N-1:0] exp_rd();
    case (bus_addr)
      3'd0: return m_p2;
      3'd1: return m_dout;
      3'd2: return m_dir;
      3'd3: return m_drv;
      3'd4: return exp_oe();
      default: return '0;
    endcase
  endfunction

  // Advance one clock, update the model at the edge, check 2 ns later.
  task automatic step_and_check();
    @(posedge clk);
    if (bus_sel && bus_wr) begin
      if (bus_addr == 3'd1) m_dout = bus_wdata;
      if (bus_addr == 3'd2) m_dir  = bus_wdata;
      if (bus_addr == 3'd3) m_drv  = bus_wdata;
    end
    m_p2 = m_p1;
    m_p1 = pin_in;
    #2;
    chk("R3 pin_out", pin_out, exp_out());
    chk("R4/R5 pin_oe", pin_oe, exp_oe());
    chk("R6 pin_fast", pin_fast, m_drv);
    chk("R7 pld_in", pld_in, pin_in);
    chk("R7 pm_in", N'(pm_in), N'(pin_in[2:1]));
    chk("R10 mc_clk", N'(mc_clk), N'(cfg_clk_pin & pin_in[1]));
    chk("R11 mem_sel_out", N'(mem_sel_out),
        N'((cfg_csi_pin && pin_in[2]) ? '0 : mem_sel_in));
    chk("R2/R8/R9 bus_rdata", bus_rdata, exp_rd());
  endtask

  task automatic bus(input logic s, input logic w, input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    for (int a = 1; a < 4; a++) begin
      bus_addr = 3'(a);
      #1;
      chk("R1 reset value", bus_rdata, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: write each CPU register, then try stray writes.
    bus(1, 1, 3'd1, 8'hA5); step_and_check();
    bus(1, 1, 3'd2, 8'h3C); step_and_check();
    bus(1, 1, 3'd3, 8'hF0); step_and_check();
    bus(1, 1, 3'd0, 8'hFF); step_and_check(); // R8 write to data-in ignored
    bus(1, 1, 3'd4, 8'hFF); step_and_check(); // R9 write to enable-out ignored
    bus(1, 1, 3'd7, 8'h00); step_and_check(); // R9 out-of-range reads 0
    bus(0, 1, 3'd1, 8'h00); step_and_check(); // R2 no strobe, no write
    for (int a = 1; a < 4; a++) begin bus(0, 0, 3'(a), '0); step_and_check(); end

    // Directed: dedicated pins and standby.
    @(negedge clk);
    bus_sel = 0; cfg_clk_pin = 1; cfg_csi_pin = 1; m_dir = m_dir; 
    pin_in = 8'h06; mem_sel_in = 4'hF; bus_addr = 3'd4;
    step_and_check(); // R5, R10, R11
    @(negedge clk); pin_in = 8'h02; step_and_check(); // R11 pin low -> pass
    @(negedge clk); cfg_csi_pin = 0; pin_in = 8'h04; step_and_check(); // R11 not dedicated

    // Constrained random.
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      bus_sel     = ($urandom % 4) != 0;
      bus_wr      = $urandom % 2;
      bus_addr    = 3'($urandom % 8);
      bus_wdata   = N'($urandom);
      cfg_out_cs  = N'($urandom);
      cfg_oe_pt   = N'($urandom);
      cfg_clk_pin = ($urandom % 3) == 0;
      cfg_csi_pin = ($urandom % 3) == 0;
      ext_cs      = N'($urandom);
      pt_oe       = N'($urandom);
      pin_in      = N'($urandom);
      mem_sel_in  = M'($urandom);
      step_and_check();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule